// File: doc/BRIEF.md
# Host Bridge Error Router

This block sits beside a host-to-PCI bridge and turns its error events into processor notifications. Each error source sets its own sticky bit in a status register. Software chooses, per source, whether that bit raises a machine check, a standard interrupt, both, or neither. The standard interrupt is a level output. It stays high while any interrupt-enabled status bit is set.

A machine check goes to exactly one of three processors. When the first error after an all-clear status arrives, the block records the master ID of the faulting transaction, together with a flag that says whether the ID is known. If that recorded ID names a processor, the machine check goes there. Otherwise a programmable default target decides. A global machine-check enable gates every machine check. Status bits are cleared by writing 1 to them.

Top module: `herr_router`

## Requirements
- R1: After reset, all four registers read 0, `mchk_o` is 0 and `irq_o` is 0.
- R2: A high `err_evt[i]` sets status bit i (address 0). The bit stays set until a write to address 0 has bit i set. Writing 0 to a bit leaves it unchanged.
- R3: `irq_o` is high exactly while some status bit is set whose bit in the interrupt-enable register (address 2) is also set.
- R4: When status bit i and machine-check-enable bit i (address 1) are set and the global enable (address 3 bit 0) is 1, the selected `mchk_o` line rises one clock after the status bit is set. It stays high while the bit is set and falls one clock after the bit clears.
- R5: With the global enable at 0, `mchk_o` stays 0. The interrupt path is not affected.
- R6: When the recorded master ID is valid and is 00, 01 or 10, the machine check drives `mchk_o` bit 0, 1 or 2.
- R7: When the recorded ID is not valid, or is 11, the default target (address 3 bits 2:1) selects the line. A default of 11 delivers no machine check.
- R8: The attribute is captured only for an event that arrives while the whole status is 0. Address 3 bit 3 holds the valid flag and bits 5:4 hold the ID. Later events leave it unchanged until the status is fully clear.
- R9: A source with neither enable set only records its status bit.
- R10: If an event and a clear of the same bit occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 status, 1 mc enable, 2 irq enable, 3 control) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| err_evt | input | NSRC | One pulse bit per error source |
| err_mid | input | 2 | Master ID of the faulting transaction |
| err_mid_vld | input | 1 | `err_mid` is known |
| mchk_o | output | 3 | Machine-check line per processor |
| irq_o | output | 1 | Level-sensitive standard interrupt |

## Verification
The hardest case to reach is a second error that arrives while the first one is still pending, because its master ID must not replace the recorded one. The bench sets one source with one ID and then a second source with a different ID. It checks the control readback and the selected machine-check line. It then clears the bits one at a time to show that a new ID is captured only after the status is fully clear. A second hard case is a clear and a new event on the same bit in one cycle. The bench drives both on the same edge.

// File: rtl/herr_pkg.sv
package herr_pkg;
    localparam int MID_W = 2;
    localparam logic [MID_W-1:0] MID_NONE = '1;

    typedef struct packed {
        logic             vld;
        logic [MID_W-1:0] mid;
    } herr_attr_t;
endpackage

// File: rtl/herr_capture.sv
module herr_capture
    import herr_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      evt,
    input  logic [NSRC-1:0]      clr,
    input  logic [MID_W-1:0]     mid,
    input  logic                 mid_vld,
    output logic [NSRC-1:0]      status,
    output herr_attr_t           attr
);
    typedef struct packed {
        logic [NSRC-1:0] status;
        herr_attr_t      attr;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set wins over clear
        st_d.status = (st_q.status & ~clr) | evt;
        if (st_q.status == '0 && evt != '0) begin
            st_d.attr.vld = mid_vld;
            st_d.attr.mid = mid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign attr   = st_q.attr;
endmodule

// File: rtl/herr_steer.sv
module herr_steer
    import herr_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int NCPU = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      status,
    input  logic [NSRC-1:0]      mc_en,
    input  logic [NSRC-1:0]      irq_en,
    input  logic                 glb_en,
    input  logic [MID_W-1:0]     dflt,
    input  herr_attr_t           attr,
    output logic [NCPU-1:0]      mchk,
    output logic                 irq
);
    typedef struct packed {
        logic [NCPU-1:0] mchk;
    } steer_t;

    steer_t st_d, st_q;
    logic [MID_W-1:0] tgt;
    logic             fire;

    always_comb begin
        if (attr.vld && attr.mid != MID_NONE) tgt = attr.mid;
        else                                  tgt = dflt;
        fire = glb_en && ((status & mc_en) != '0);
        st_d = '0;
        for (int c = 0; c < NCPU; c++) begin
            st_d.mchk[c] = fire && (tgt == MID_W'(c));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mchk = st_q.mchk;
    assign irq  = (status & irq_en) != '0;
endmodule

// File: rtl/herr_router.sv
module herr_router
    import herr_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [NSRC-1:0]  err_evt,
    input  logic [1:0]       err_mid,
    input  logic             err_mid_vld,
    output logic [2:0]       mchk_o,
    output logic             irq_o
);
    localparam int NCPU = (2 ** MID_W) - 1;

    typedef struct packed {
        logic [NSRC-1:0]  mc_en;
        logic [NSRC-1:0]  irq_en;
        logic             glb;
        logic [MID_W-1:0] dflt;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [NSRC-1:0]  clr_w;
    logic [NSRC-1:0]  stat_w;
    herr_attr_t       attr_w;
    logic             glb_w;

    always_comb begin
        cfg_d = cfg_q;
        clr_w = '0;
        if (cfg_we) begin
            unique case (cfg_addr)
                2'd0: clr_w        = cfg_wdata[NSRC-1:0];
                2'd1: cfg_d.mc_en  = cfg_wdata[NSRC-1:0];
                2'd2: cfg_d.irq_en = cfg_wdata[NSRC-1:0];
                default: begin
                    cfg_d.glb  = cfg_wdata[0];
                    cfg_d.dflt = cfg_wdata[2:1];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign glb_w = cfg_q.glb;

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            2'd0: cfg_rdata[NSRC-1:0] = stat_w;
            2'd1: cfg_rdata[NSRC-1:0] = cfg_q.mc_en;
            2'd2: cfg_rdata[NSRC-1:0] = cfg_q.irq_en;
            default: begin
                cfg_rdata[0]   = cfg_q.glb;
                cfg_rdata[2:1] = cfg_q.dflt;
                cfg_rdata[3]   = attr_w.vld;
                cfg_rdata[5:4] = attr_w.mid;
            end
        endcase
    end

    herr_capture #(.NSRC(NSRC)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (err_evt),
        .clr     (clr_w),
        .mid     (err_mid),
        .mid_vld (err_mid_vld),
        .status  (stat_w),
        .attr    (attr_w)
    );

    herr_steer #(.NSRC(NSRC), .NCPU(NCPU)) u_steer (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (stat_w),
        .mc_en  (cfg_q.mc_en),
        .irq_en (cfg_q.irq_en),
        .glb_en (cfg_q.glb),
        .dflt   (cfg_q.dflt),
        .attr   (attr_w),
        .mchk   (mchk_o),
        .irq    (irq_o)
    );
endmodule

// File: rtl/herr_chk.sv
module herr_chk
    import herr_pkg::*;
#(
    parameter int NSRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [NSRC-1:0]  status,
    input logic [NSRC-1:0]  mc_en,
    input herr_attr_t       attr,
    input logic             glb_en,
    input logic [2:0]       mchk
);
    // R6: at most one processor gets a machine check
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mchk));

    // R2: no status bit falls without a status write
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == 2'd0) |=> (($past(status) & ~status) == '0));

    // R5: global enable off blocks machine checks on the next cycle
    a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (mchk == '0));

    // R4: a machine check needs an enabled pending source one cycle earlier
    a_r4_mc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk != '0) |-> ($past(status & mc_en) != '0));

    // R8: the attribute is frozen while any error is pending
    a_r8_attr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |=> $stable(attr));
endmodule

bind herr_router herr_chk #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .status   (stat_w),
    .mc_en    (cfg_q.mc_en),
    .attr     (attr_w),
    .glb_en   (glb_w),
    .mchk     (mchk_o)
);

// File: tb/sim_herr_router.sv
`timescale 1ns/1ps
module sim_herr_router;
    localparam int NSRC = 8;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            cfg_we = 0;
    logic [1:0]      cfg_addr = 0;
    logic [31:0]     cfg_wdata = 0;
    logic [31:0]     cfg_rdata;
    logic [NSRC-1:0] err_evt = 0;
    logic [1:0]      err_mid = 0;
    logic            err_mid_vld = 0;
    logic [2:0]      mchk_o;
    logic            irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    herr_router #(.NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_evt(err_evt),
        .err_mid(err_mid), .err_mid_vld(err_mid_vld), .mchk_o(mchk_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m, input logic [1:0] id, input logic v);
        @(negedge clk);
        err_evt = m; err_mid = id; err_mid_vld = v;
        @(negedge clk);
        err_evt = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 mchk", 32'(mchk_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        pulse(8'h04, 2'b00, 1);
        rd(0, v); chk("R2 set", v, 32'h04);
        chk("R9 irq", 32'(irq_o), 0);
        @(negedge clk);
        chk("R9 mchk", 32'(mchk_o), 0);
        wr(0, 32'h00);
        rd(0, v); chk("R2 write0 keeps", v, 32'h04);
        wr(0, 32'h04);
        rd(0, v); chk("R2 w1c", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(2, 32'h02);
        pulse(8'h02, 2'b00, 0);
        chk("R3 irq on", 32'(irq_o), 1);
        pulse(8'h01, 2'b00, 0);
        wr(0, 32'h02);
        rd(0, v); chk("R3 status", v, 32'h01);
        chk("R3 irq off", 32'(irq_o), 0);
        wr(0, 32'h01);
        wr(2, 32'h00);
    endtask

    task automatic t_mc();
        wr(3, 32'h1);
        wr(1, 32'h08);
        pulse(8'h08, 2'b01, 1);
        chk("R4 latency", 32'(mchk_o), 0);
        @(negedge clk);
        chk("R6 cpu1", 32'(mchk_o), 32'h2);
        repeat (3) @(negedge clk);
        chk("R4 hold", 32'(mchk_o), 32'h2);
        wr(0, 32'h08);
        chk("R4 one more cycle", 32'(mchk_o), 32'h2);
        @(negedge clk);
        chk("R4 drop", 32'(mchk_o), 0);
    endtask

    task automatic t_default();
        wr(3, 32'h5);           // glb, default 10
        pulse(8'h08, 2'b11, 1);
        @(negedge clk);
        chk("R7 id11", 32'(mchk_o), 32'h4);
        wr(0, 32'h08);
        wr(3, 32'h3);           // glb, default 01
        pulse(8'h08, 2'b00, 0);
        @(negedge clk);
        chk("R7 invalid", 32'(mchk_o), 32'h2);
        wr(0, 32'h08);
        wr(3, 32'h7);           // glb, default 11
        pulse(8'h08, 2'b11, 0);
        @(negedge clk);
        chk("R7 default11", 32'(mchk_o), 0);
        wr(0, 32'h08);
    endtask

    task automatic t_global();
        wr(3, 32'h0);
        wr(2, 32'h08);
        pulse(8'h08, 2'b00, 1);
        @(negedge clk);
        chk("R5 irq", 32'(irq_o), 1);
        chk("R5 mchk", 32'(mchk_o), 0);
        wr(0, 32'h08);
        wr(2, 32'h00);
    endtask

    task automatic t_attr();
        logic [31:0] v;
        wr(3, 32'h1);
        wr(1, 32'h03);
        pulse(8'h01, 2'b10, 1);
        pulse(8'h02, 2'b00, 1);
        rd(3, v); chk("R8 first kept", v, 32'h1 | 32'h8 | (32'h2 << 4));
        chk("R8 cpu2", 32'(mchk_o), 32'h4);
        wr(0, 32'h01);
        rd(3, v); chk("R8 partial clear", v, 32'h1 | 32'h8 | (32'h2 << 4));
        wr(0, 32'h02);
        pulse(8'h02, 2'b01, 1);
        rd(3, v); chk("R8 recapture", v, 32'h1 | 32'h8 | (32'h1 << 4));
        @(negedge clk);
        chk("R6 cpu1 again", 32'(mchk_o), 32'h2);
        wr(0, 32'h02);
    endtask

    task automatic t_race();
        logic [31:0] v;
        pulse(8'h10, 2'b00, 0);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 0; cfg_wdata = 32'h10; err_evt = 8'h10;
        @(negedge clk);
        cfg_we = 0; err_evt = 0;
        rd(0, v); chk("R10 set wins", v, 32'h10);
        wr(0, 32'h10);
        rd(0, v); chk("R10 cleared", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_sticky();
        t_irq();
        t_mc();
        t_default();
        t_global();
        t_attr();
        t_race();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule